// File: doc/BRIEF.md
# Sparse Neighbor-Aware Channel Readout

This block decides, at the close of a hit window, which of its 64 front-end channels are worth reading, and then sends one word per chosen channel through a single output stream. A channel is chosen when it fired and is not masked. When neighbor mode is on, an unmasked channel that did not fire is also chosen if a channel next to it fired. This lets signals that stayed under the threshold be recovered. The lowest and highest channels take part in this through side lines shared with the chips on either side. Each chip reports the fired state of its end channels on those lines and reads its neighbors' end channels from them.

A single start pulse captures the hit flags, mask, neighbor bit and per-channel payloads. A token then walks upward through the chosen channels only. It moves past any run of unchosen channels in one step. Each holder presents one word, and the token moves on when the consumer accepts that word. A done flag marks the end of the list. Done comes up on the cycle after start when nothing was chosen.

Top module: `nbr_token_readout`

## Requirements
- R1: After reset, word_valid_o and done_o are both low until a start pulse is taken.
- R2: An unmasked channel whose hit flag is high at start is read out, with its neighbor-only flag at 0.
- R3: An unmasked channel that did not fire, and is not next to a fired unmasked channel, is never read out. This is also true in neighbor mode.
- R4: With nbr_en_i high at start, an unmasked channel that did not fire is read out with its neighbor-only flag at 1 when channel i-1 or i+1 fired and is unmasked. With nbr_en_i low, such a channel is not read out.
- R5: With nbr_en_i high, nbr_in_lo_i counts as a fired channel below channel 0, and nbr_in_hi_i counts as one above channel 63.
- R6: nbr_out_lo_o equals hit of channel 0 AND NOT its mask, and nbr_out_hi_o does the same for channel 63, combinationally from the inputs.
- R7: A masked channel is never read out, and its hit does not select its neighbors.
- R8: Words come out in strictly ascending channel order. Exactly one word leaves per cycle in which word_valid_o and out_ready_i are both high. While out_ready_i is low, the word stays stable.
- R9: Word layout: bits [16:11] hold the channel address, bit 10 holds the neighbor-only flag, and bits [9:0] hold the payload captured from data_i[10*ch +: 10].
- R10: done_o rises in the cycle after the last word is accepted, or in the cycle after start when no channel was chosen. It then stays high until the next accepted start, and it is never high together with word_valid_o.
- R11: A start pulse while words are still pending is ignored, and the current readout continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Closes the hit window and captures the inputs |
| hit_i | input | 64 | Per-channel above-threshold flags |
| mask_i | input | 64 | Per-channel exclusion |
| data_i | input | 640 | Per-channel 10-bit payloads, channel ch at [10*ch +: 10] |
| nbr_en_i | input | 1 | Enables selection of channels next to a fired channel |
| nbr_in_lo_i | input | 1 | Fired state of the lower neighbor chip's top channel |
| nbr_in_hi_i | input | 1 | Fired state of the upper neighbor chip's bottom channel |
| nbr_out_lo_o | output | 1 | Fired state of channel 0, sent to the lower chip |
| nbr_out_hi_o | output | 1 | Fired state of channel 63, sent to the upper chip |
| out_ready_i | input | 1 | Consumer accepts the current word |
| word_o | output | 17 | Address, neighbor-only flag and payload |
| word_valid_o | output | 1 | word_o holds a chosen channel |
| done_o | output | 1 | All chosen channels have been sent |

## Verification
The selection is tried with several patterns. Sparse isolated hits with neighbor mode off show zero suppression on its own. Two fired channels one apart in neighbor mode show that a shared neighbor is sent only once. Masked hits next to masked and unmasked channels separate hit masking from neighbor masking. Side-line-only patterns, and hits on channels 0 and 63, exercise both chip edges in each mode. A full 64-channel pattern and an empty pattern stress the token's longest and shortest walks. A start pulse sent while the consumer stalls shows that a readout in flight cannot be overwritten. Random back-pressure throughout shows the hold rule and the ordering.

// File: rtl/nbr_ro_pkg.sv
package nbr_ro_pkg;
    localparam int NRO_NUM_CH = 64;
    localparam int NRO_DATA_W = 10;

    function automatic int nro_word_w(input int num_ch, input int data_w);
        return $clog2(num_ch) + 1 + data_w;
    endfunction
endpackage

// File: rtl/nro_select.sv
module nro_select #(
    parameter int NUM_CH = 64
) (
    input  logic [NUM_CH-1:0] hit_i,
    input  logic [NUM_CH-1:0] mask_i,
    input  logic              nbr_en_i,
    input  logic              nbr_in_lo_i,
    input  logic              nbr_in_hi_i,
    output logic [NUM_CH-1:0] sel_o,
    output logic [NUM_CH-1:0] nbr_only_o,
    output logic              nbr_out_lo_o,
    output logic              nbr_out_hi_o
);
    logic [NUM_CH-1:0] fired;
    logic [NUM_CH+1:0] ring;

    assign fired        = hit_i & ~mask_i;
    assign ring         = {nbr_in_hi_i, fired, nbr_in_lo_i};
    assign nbr_out_lo_o = fired[0];
    assign nbr_out_hi_o = fired[NUM_CH-1];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        logic adj;
        assign adj           = nbr_en_i & (ring[g] | ring[g+2]);
        assign sel_o[g]      = fired[g] | (~mask_i[g] & adj);
        assign nbr_only_o[g] = sel_o[g] & ~fired[g];
    end
endmodule

// File: rtl/nro_pick_low.sv
module nro_pick_low #(
    parameter int NUM_CH = 64,
    localparam int IDX_W = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0] req_i,
    output logic              any_o,
    output logic [IDX_W-1:0]  idx_o
);
    always_comb begin
        idx_o = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = IDX_W'(i);
        end
    end

    assign any_o = |req_i;
endmodule

// File: rtl/nbr_token_readout.sv
module nbr_token_readout
    import nbr_ro_pkg::*;
#(
    parameter int NUM_CH = NRO_NUM_CH,
    parameter int DATA_W = NRO_DATA_W,
    localparam int IDX_W  = $clog2(NUM_CH),
    localparam int WORD_W = IDX_W + 1 + DATA_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic [NUM_CH-1:0]        hit_i,
    input  logic [NUM_CH-1:0]        mask_i,
    input  logic [NUM_CH*DATA_W-1:0] data_i,
    input  logic                     nbr_en_i,
    input  logic                     nbr_in_lo_i,
    input  logic                     nbr_in_hi_i,
    output logic                     nbr_out_lo_o,
    output logic                     nbr_out_hi_o,
    input  logic                     out_ready_i,
    output logic [WORD_W-1:0]        word_o,
    output logic                     word_valid_o,
    output logic                     done_o
);
    typedef struct packed {
        logic                           busy;
        logic [NUM_CH-1:0]              pend;
        logic [NUM_CH-1:0]              nflag;
        logic [NUM_CH-1:0][DATA_W-1:0]  pay;
    } ro_state_t;

    ro_state_t s_d, s_q;

    logic [NUM_CH-1:0] sel_w, nbr_only_w;
    logic              any_w;
    logic [IDX_W-1:0]  idx_w;
    logic              take_start;

    nro_select #(.NUM_CH(NUM_CH)) u_select (
        .hit_i       (hit_i),
        .mask_i      (mask_i),
        .nbr_en_i    (nbr_en_i),
        .nbr_in_lo_i (nbr_in_lo_i),
        .nbr_in_hi_i (nbr_in_hi_i),
        .sel_o       (sel_w),
        .nbr_only_o  (nbr_only_w),
        .nbr_out_lo_o(nbr_out_lo_o),
        .nbr_out_hi_o(nbr_out_hi_o)
    );

    nro_pick_low #(.NUM_CH(NUM_CH)) u_pick (
        .req_i(s_q.pend),
        .any_o(any_w),
        .idx_o(idx_w)
    );

    assign take_start = start_i & ~any_w;

    always_comb begin
        s_d = s_q;
        if (take_start) begin
            s_d.busy  = 1'b1;
            s_d.pend  = sel_w;
            s_d.nflag = nbr_only_w;
            s_d.pay   = data_i;
        end else if (any_w && out_ready_i) begin
            s_d.pend[idx_w] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign word_valid_o = s_q.busy & any_w;
    assign done_o       = s_q.busy & ~any_w;
    assign word_o       = {idx_w, s_q.nflag[idx_w], s_q.pay[idx_w]};

    // R1: nothing is presented before the first accepted start
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.busy |-> (!word_valid_o && !done_o));

    // R8: a stalled word is held unchanged
    assert_hold_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid_o && !out_ready_i) |=> (word_valid_o && $stable(word_o)));

    // R8: after each accepted word the next address is higher
    assert_ascend_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid_o && out_ready_i) |=>
            (!word_valid_o || (word_o[WORD_W-1 -: IDX_W] > $past(word_o[WORD_W-1 -: IDX_W]))));

    // R10: done persists until a new start
    assert_done_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o);

    // R11: a start during a pending readout leaves the stream in place
    assert_busy_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid_o && start_i && !out_ready_i) |=> $stable(word_o));
endmodule

// File: tb/nbr_token_readout_bench.sv
module nbr_token_readout_bench;
    localparam int NCH = 64;
    localparam int DW  = 10;
    localparam int WW  = 17;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start_i = 1'b0;
    logic [NCH-1:0]  hit_i = '0;
    logic [NCH-1:0]  mask_i = '0;
    logic [NCH*DW-1:0] data_i = '0;
    logic            nbr_en_i = 1'b0;
    logic            nbr_in_lo_i = 1'b0;
    logic            nbr_in_hi_i = 1'b0;
    logic            nbr_out_lo_o, nbr_out_hi_o;
    logic            out_ready_i = 1'b0;
    logic [WW-1:0]   word_o;
    logic            word_valid_o, done_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit hold_ready = 1'b0;
    string tag = "R2";
    logic [WW-1:0] exp_q[$];
    logic          prev_stall = 1'b0;
    logic [WW-1:0] prev_word = '0;

    always #10 clk = ~clk;

    nbr_token_readout u_nbr_token_readout (
        .clk, .rst_n, .start_i, .hit_i, .mask_i, .data_i, .nbr_en_i,
        .nbr_in_lo_i, .nbr_in_hi_i, .nbr_out_lo_o, .nbr_out_hi_o,
        .out_ready_i, .word_o, .word_valid_o, .done_o
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic logic [DW-1:0] pay(input int ch, input int seed);
        return DW'((ch * 37 + seed * 11 + 5) % 1024);
    endfunction

    // expected list from the requirements
    task automatic push_expected(input logic [NCH-1:0] h, input logic [NCH-1:0] m,
                                 input logic en, input logic lo, input logic hi, input int seed);
        for (int i = 0; i < NCH; i++) begin
            logic self_f, left_f, right_f, pick;
            self_f  = h[i] && !m[i];
            left_f  = (i == 0)       ? lo : (h[i-1] && !m[i-1]);
            right_f = (i == NCH - 1) ? hi : (h[i+1] && !m[i+1]);
            pick    = self_f || (!m[i] && en && (left_f || right_f));
            if (pick) exp_q.push_back({6'(i), !self_f, pay(i, seed)});
        end
    endtask

    task automatic apply(input logic [NCH-1:0] h, input logic [NCH-1:0] m,
                         input logic en, input logic lo, input logic hi, input int seed);
        hit_i = h; mask_i = m; nbr_en_i = en; nbr_in_lo_i = lo; nbr_in_hi_i = hi;
        for (int i = 0; i < NCH; i++) data_i[i*DW +: DW] = pay(i, seed);
    endtask

    task automatic run_window(input string t, input logic [NCH-1:0] h, input logic [NCH-1:0] m,
                              input logic en, input logic lo, input logic hi, input int seed);
        int wait_n;
        bit empty_sel;
        @(negedge clk);
        tag = t;
        push_expected(h, m, en, lo, hi, seed);
        empty_sel = (exp_q.size() == 0);
        apply(h, m, en, lo, hi, seed);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        apply('0, '0, 1'b0, 1'b0, 1'b0, seed + 99);
        if (empty_sel) check({t, " R10 immediate done"}, 32'(done_o), 32'd1);
        wait_n = 0;
        while (!done_o && wait_n < 2000) begin
            @(negedge clk);
            wait_n++;
        end
        check({t, " R10 done reached"}, 32'(done_o), 32'd1);
        check({t, " R10 no valid with done"}, 32'(word_valid_o), 32'd0);
        check({t, " R10 all words out before done"}, 32'(exp_q.size()), 32'd0);
        exp_q.delete();
        repeat (2) @(negedge clk);
        check({t, " R10 done held"}, 32'(done_o), 32'd1);
    endtask

    // monitor: chooses ready, then compares the presented word
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall) begin
                check({tag, " R8 hold while stalled"}, 32'(word_o), 32'(prev_word));
                check({tag, " R8 valid while stalled"}, 32'(word_valid_o), 32'd1);
            end
            out_ready_i = hold_ready ? 1'b0 : (($urandom % 4) != 0);
            if (word_valid_o && out_ready_i) begin
                if (exp_q.size() == 0) begin
                    checks++;
                    failures++;
                    $display("FAIL %s R3 unexpected word actual=%0h expected=none", tag, word_o);
                end else begin
                    logic [WW-1:0] e;
                    e = exp_q.pop_front();
                    check({tag, " R9 word"}, 32'(word_o), 32'(e));
                end
            end
            prev_stall = word_valid_o && !out_ready_i;
            prev_word  = word_o;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [NCH-1:0] h, m;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 valid after reset", 32'(word_valid_o), 32'd0);
        check("R1 done after reset", 32'(done_o), 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 valid idle", 32'(word_valid_o), 32'd0);
        check("R1 done idle", 32'(done_o), 32'd0);

        // R6 edge outputs
        hit_i = 64'h8000_0000_0000_0001; mask_i = '0; #1;
        check("R6 out lo", 32'(nbr_out_lo_o), 32'd1);
        check("R6 out hi", 32'(nbr_out_hi_o), 32'd1);
        mask_i = 64'h8000_0000_0000_0000; #1;
        check("R6 out hi masked", 32'(nbr_out_hi_o), 32'd0);
        check("R6 out lo unmasked", 32'(nbr_out_lo_o), 32'd1);
        hit_i = 64'h0000_0000_0000_0002; mask_i = '0; #1;
        check("R6 out lo from ch1 only", 32'(nbr_out_lo_o), 32'd0);
        hit_i = '0;

        // R2 R3 sparse hits, neighbor mode off
        h = '0; h[5] = 1; h[20] = 1; h[21] = 1;
        run_window("R2/R3 sparse", h, '0, 1'b0, 1'b0, 1'b0, 1);
        // R4 neighbor mode with shared neighbor, R7 mask next to hit
        h = '0; h[4] = 1; h[6] = 1; h[30] = 1;
        m = '0; m[31] = 1;
        run_window("R4/R7 neighbors", h, m, 1'b1, 1'b0, 1'b0, 2);
        // R7 masked hit selects nobody, R10 empty
        h = '0; h[40] = 1; m = '0; m[40] = 1;
        run_window("R7 masked hit", h, m, 1'b1, 1'b0, 1'b0, 3);
        // R5 side lines in neighbor mode
        run_window("R5 side lines on", '0, '0, 1'b1, 1'b1, 1'b1, 4);
        run_window("R5 side lines off", '0, '0, 1'b0, 1'b1, 1'b1, 5);
        // R5 R4 hits at the ends
        h = '0; h[0] = 1; h[63] = 1;
        run_window("R4/R5 end hits", h, '0, 1'b1, 1'b0, 1'b0, 6);
        // R8 full pattern
        run_window("R8 all hits", '1, '0, 1'b1, 1'b1, 1'b1, 7);

        // R11 start ignored while pending
        @(negedge clk);
        hold_ready = 1'b1;
        tag = "R11 busy start";
        h = '0; h[10] = 1; h[50] = 1;
        push_expected(h, '0, 1'b0, 1'b0, 1'b0, 8);
        apply(h, '0, 1'b0, 1'b0, 1'b0, 8);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (2) @(negedge clk);
        apply(64'h0000_0F00_0000_0003, '0, 1'b1, 1'b0, 1'b0, 9);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        check("R11 first word kept", 32'(word_o), 32'({6'd10, 1'b0, pay(10, 8)}));
        hold_ready = 1'b0;
        begin
            int n;
            n = 0;
            while (!done_o && n < 500) begin
                @(negedge clk);
                n++;
            end
        end
        check("R11 only first window read", 32'(exp_q.size()), 32'd0);
        check("R11 done", 32'(done_o), 32'd1);
        exp_q.delete();

        // restart after done works
        h = '0; h[33] = 1;
        run_window("R2 restart", h, '0, 1'b1, 1'b0, 1'b0, 10);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule